// File: doc/BRIEF.md
# Dual-Channel Converter Serial Command Interface

This block is the digital front end of a two-channel, 12-bit converter. A host shifts a 16-bit command into it over a three-wire serial link made of an active-low select, a clock and a data line. Data is sampled on rising clock edges while the select is low. The select, clock and data lines are synchronised into the system clock domain. Clock edges are found by comparing the current and previous synchronised levels. For this to work, the system clock must run at least four times faster than the serial clock. Serial clock rates up to 10 MHz are supported.

Each channel holds two registers: an input register and an output register. When the select line returns high, the block checks that exactly 16 bits arrived. If so, it decodes the command and then loads an input register, loads an input register and updates the matching output register, or moves both input registers into the output registers at once. The two output registers drive the converter cores as parallel 12-bit words.

Top module: `dac2_serial_if`

## Requirements
- R1: An active-low synchronous reset clears both input registers, both output registers and the bit counter, so both outputs read 0.
- R2: While the select line is high, serial clock and data activity is ignored. No register changes and the bit count stays at zero.
- R3: Bits are sampled on the rising serial clock edge, most significant first. Frame bit 15 is the channel address, bits 14:13 are the command, bits 12:1 are the data word (bit 12 its MSB), and bit 0 is a trailing bit that is ignored.
- R4: Registers change only in the cycle that follows the detected rise of the select line, never while bits are being shifted.
- R5: Command 00 loads the data word into the addressed input register and leaves both outputs unchanged.
- R6: Command 01 loads the data word into the addressed input register and into the addressed output register.
- R7: Command 10 copies each input register into its own output register and ignores the address and data fields.
- R8: Command 11 changes nothing.
- R9: Address 0 targets channel A (`dac_a`) and address 1 targets channel B (`dac_b`). The other channel is left untouched.
- R10: A frame that ends after any bit count other than 16 (for example 15 or 17 bits) is discarded with no register change.
- R11: A frame sent as two 8-bit bursts, with an idle serial clock between them and the select held low throughout, is accepted the same as one continuous burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Serial select, active low, asynchronous |
| sclk | input | 1 | Serial clock, idles low, asynchronous |
| sdi | input | 1 | Serial data, sampled on rising sclk |
| dac_a | output | 12 | Channel A output register |
| dac_b | output | 12 | Channel B output register |

## Verification
The assertions check the following properties on every cycle:
- The counter stays at zero while the select line is high.
- Commits occur only on a select rise.
- The output registers hold whenever no valid frame commits.
- A wrong-length frame and a no-op command leave all registers unchanged.
- A transfer copies exactly the prior input values.
- Reset leaves every register cleared.

Some behaviours can only be shown by the bench scenarios driving real serial waveforms. These are the bit order and field positions, the mapping from address to channel, load-and-update, acceptance of a split frame, and immunity to clocking while deselected.

// File: rtl/dacif_pkg.sv
`timescale 1ns/1ps
// Shared constants and the command encoding of the serial converter interface.
package dacif_pkg;
    localparam int NCH    = 2;                       // converter channels
    localparam int ADDR_W = $clog2(NCH);             // address field width

    // Two-bit command field values.
    typedef enum logic [1:0] {
        CMD_LOAD     = 2'b00,   // input register only
        CMD_LOAD_UPD = 2'b01,   // input and output register of one channel
        CMD_XFER     = 2'b10,   // all input registers to output registers
        CMD_NOP      = 2'b11
    } cmd_e;
endpackage

// File: rtl/dacif_sync.sv
`timescale 1ns/1ps
// Brings the three asynchronous serial pins into the clk domain.
// A chain of STAGES flops per pin is followed by one extra flop, which is used
// for edge detection. Assumes clk runs at least 4x the serial clock, so that
// every level lasts at least two clk cycles.
module dacif_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdi,
    output logic cs_high,     // synchronised select level (deselected)
    output logic cs_rise,     // one-cycle pulse on select release
    output logic sclk_rise,   // one-cycle pulse on serial clock rise
    output logic sdi_s        // synchronised data level
);
    localparam int NPIN = 3;

    logic [NPIN-1:0] chain [STAGES];
    logic [NPIN-1:0] prev;

    // Purpose: synchronizer chain plus an edge-detect delay stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= 3'b001;  // cs_n idles high
            prev <= 3'b001;
        end else begin
            chain[0] <= {sdi, sclk, cs_n};
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            prev <= chain[STAGES-1];
        end
    end

    assign cs_high   = chain[STAGES-1][0];
    assign cs_rise   = chain[STAGES-1][0] & ~prev[0];
    assign sclk_rise = chain[STAGES-1][1] & ~prev[1];
    assign sdi_s     = chain[STAGES-1][2];
endmodule

// File: rtl/dacif_shift.sv
`timescale 1ns/1ps
// Frame shifter and bit counter. Shifts in one bit MSB-first on every sampled
// serial clock rise while the select is low. The counter saturates one past
// the frame length, so an over-long frame is never mistaken for a valid one.
// frame_ok is raised on the select release only when exactly FRAME_W bits arrived.
module dacif_shift #(
    parameter int FRAME_W = 16,
    parameter int CNT_W   = $clog2(FRAME_W + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_high,
    input  logic               cs_rise,
    input  logic               sclk_rise,
    input  logic               sdi_s,
    output logic [FRAME_W-1:0] word,
    output logic [CNT_W-1:0]   bit_cnt,
    output logic               frame_ok
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

    // Purpose: shift data and count bits while selected, clear count when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word    <= '0;
            bit_cnt <= '0;
        end else if (cs_high) begin
            bit_cnt <= '0;
        end else if (sclk_rise) begin
            word <= {word[FRAME_W-2:0], sdi_s};
            if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Purpose: qualify the frame at the select release.
    assign frame_ok = cs_rise && (bit_cnt == CNT_FULL);
endmodule

// File: rtl/dacif_regs.sv
`timescale 1ns/1ps
// Double-buffered register bank. Decodes a validated frame into per-channel
// input and output register updates. The frame layout from MSB is address,
// two command bits, data word, and one ignored trailing bit.
module dacif_regs
    import dacif_pkg::*;
#(
    parameter int DATA_W  = 12,
    parameter int FRAME_W = ADDR_W + 2 + DATA_W + 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         commit,
    input  logic [FRAME_W-1:0]           word,
    output logic [NCH-1:0][DATA_W-1:0]   in_q,
    output logic [NCH-1:0][DATA_W-1:0]   dac_q
);
    localparam int ADDR_LO = FRAME_W - ADDR_W;
    localparam int CMD_LO  = ADDR_LO - 2;
    localparam int DATA_LO = CMD_LO - DATA_W;

    logic [ADDR_W-1:0] addr;
    cmd_e              cmd;
    logic [DATA_W-1:0] data;

    assign addr = word[ADDR_LO +: ADDR_W];
    assign cmd  = cmd_e'(word[CMD_LO +: 2]);
    assign data = word[DATA_LO +: DATA_W];

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic              hit;
        logic [DATA_W-1:0] in_r;
        logic [DATA_W-1:0] dac_r;

        assign hit = (addr == ADDR_W'(ch));

        // Purpose: apply the decoded command to this channel's pair of registers.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                in_r  <= '0;
                dac_r <= '0;
            end else if (commit) begin
                unique case (cmd)
                    CMD_LOAD:     if (hit) in_r <= data;
                    CMD_LOAD_UPD: if (hit) begin
                                      in_r  <= data;
                                      dac_r <= data;
                                  end
                    CMD_XFER:     dac_r <= in_r;
                    default:      ;
                endcase
            end
        end

        assign in_q[ch]  = in_r;
        assign dac_q[ch] = dac_r;
    end
endmodule

// File: rtl/dac2_serial_if.sv
`timescale 1ns/1ps
// Top of the dual-channel serial converter interface: synchroniser, frame
// shifter and double-buffered register bank. It assumes clk is at least 4x
// the serial clock rate.
module dac2_serial_if
    import dacif_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic [DATA_W-1:0] dac_a,
    output logic [DATA_W-1:0] dac_b
);
    localparam int FRAME_W = ADDR_W + 2 + DATA_W + 1;
    localparam int CNT_W   = $clog2(FRAME_W + 2);

    logic                       cs_high, cs_rise, sclk_rise, sdi_s;
    logic [FRAME_W-1:0]         word;
    logic [CNT_W-1:0]           bit_cnt;
    logic                       frame_ok;
    logic [NCH-1:0][DATA_W-1:0] in_q;
    logic [NCH-1:0][DATA_W-1:0] dac_q;

    dacif_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .cs_high(cs_high), .cs_rise(cs_rise), .sclk_rise(sclk_rise), .sdi_s(sdi_s)
    );

    dacif_shift #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .cs_high(cs_high), .cs_rise(cs_rise),
        .sclk_rise(sclk_rise), .sdi_s(sdi_s),
        .word(word), .bit_cnt(bit_cnt), .frame_ok(frame_ok)
    );

    dacif_regs #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .commit(frame_ok), .word(word),
        .in_q(in_q), .dac_q(dac_q)
    );

    assign dac_a = dac_q[0];
    assign dac_b = dac_q[1];
endmodule

// File: rtl/dacif_chk.sv
`timescale 1ns/1ps
// Assertion checker for dac2_serial_if, attached by bind below.
module dacif_chk #(
    parameter int DATA_W  = 12,
    parameter int FRAME_W = 16,
    parameter int CNT_W   = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cs_high,
    input logic               cs_rise,
    input logic               frame_ok,
    input logic [CNT_W-1:0]   bit_cnt,
    input logic [FRAME_W-1:0] word,
    input logic [DATA_W-1:0]  in_a,
    input logic [DATA_W-1:0]  in_b,
    input logic [DATA_W-1:0]  dac_a,
    input logic [DATA_W-1:0]  dac_b
);
    logic [1:0] cmd;
    assign cmd = word[FRAME_W-2 -: 2];

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dac_a == '0 && dac_b == '0 && in_a == '0 && in_b == '0));

    p_idle_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_high |=> (bit_cnt == '0));

    p_commit_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok |-> cs_rise);

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_ok |=> ($stable(dac_a) && $stable(dac_b)));

    p_load_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_ok && cmd == 2'b00) |=> ($stable(dac_a) && $stable(dac_b)));

    p_xfer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_ok && cmd == 2'b10) |=> (dac_a == $past(in_a) && dac_b == $past(in_b)));

    p_nop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_ok && cmd == 2'b11) |=>
        ($stable(dac_a) && $stable(dac_b) && $stable(in_a) && $stable(in_b)));

    p_discard_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && bit_cnt != CNT_W'(FRAME_W)) |=>
        ($stable(dac_a) && $stable(dac_b) && $stable(in_a) && $stable(in_b)));
endmodule

bind dac2_serial_if dacif_chk #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_high(cs_high), .cs_rise(cs_rise),
    .frame_ok(frame_ok), .bit_cnt(bit_cnt), .word(word),
    .in_a(in_q[0]), .in_b(in_q[1]), .dac_a(dac_a), .dac_b(dac_b)
);

// File: tb/sim_dac2_serial_if.sv
`timescale 1ns/1ps
// Self-checking bench for dac2_serial_if. Runs a 10 MHz serial clock against a 125 MHz system clock.
module sim_dac2_serial_if;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic [11:0] dac_a, dac_b;
    int          n_chk = 0;
    int          n_err = 0;

    always #4 clk = ~clk;

    dac2_serial_if u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
                       .sdi(sdi), .dac_a(dac_a), .dac_b(dac_b));

    // Each entry is {frame, expected dac_a, expected dac_b}.
    // Frame = {addr, cmd[1:0], data[11:0], trailing bit}.
    localparam int NV = 7;
    localparam logic [39:0] VEC [NV] = '{
        {1'b0, 2'b00, 12'h123, 1'b0, 12'h000, 12'h000},  // R5 load A only
        {1'b1, 2'b01, 12'hABC, 1'b0, 12'h000, 12'hABC},  // R6 R9 load+update B
        {1'b1, 2'b10, 12'hFFF, 1'b0, 12'h123, 12'hABC},  // R7 transfer both
        {1'b0, 2'b01, 12'h456, 1'b0, 12'h456, 12'hABC},  // R6 R9 load+update A
        {1'b1, 2'b00, 12'h789, 1'b0, 12'h456, 12'hABC},  // R5 load B only
        {1'b0, 2'b11, 12'hFFF, 1'b1, 12'h456, 12'hABC},  // R8 no-op
        {1'b0, 2'b10, 12'h000, 1'b0, 12'h456, 12'h789}   // R7 R3 transfer
    };

    task automatic check(input string req, input logic [11:0] ea, input logic [11:0] eb);
        @(negedge clk);
        n_chk++;
        if (dac_a !== ea || dac_b !== eb) begin
            n_err++;
            $display("FAIL %s: dac_a=%h dac_b=%h expected dac_a=%h dac_b=%h",
                     req, dac_a, dac_b, ea, eb);
        end
    endtask

    // Shift nbits of w, MSB first, then pad with zeros past 16 bits.
    // Optionally pause after the first byte; optionally leave the select low.
    task automatic send(input logic [15:0] w, input int nbits, input bit split, input bit keep_low);
        cs_n = 1'b0;
        #100;
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 16) ? w[15-i] : 1'b0;
            #50 sclk = 1'b1;
            #50 sclk = 1'b0;
            if (split && i == 7) #400;
        end
        #100;
        if (!keep_low) begin
            cs_n = 1'b1;
            #200;
        end
    endtask

    initial begin
        #1_200_000;
        n_err++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        check("R1 reset state", 12'h000, 12'h000);
        @(negedge clk) rst_n = 1'b1;
        repeat (3) @(posedge clk);

        for (int v = 0; v < NV; v++) begin
            send(VEC[v][39:24], 16, 1'b0, 1'b0);
            check($sformatf("R3/R5-R9 vector %0d", v), VEC[v][23:12], VEC[v][11:0]);
        end

        // R11: frame split into two bursts
        send({1'b0, 2'b01, 12'h5A5, 1'b0}, 16, 1'b1, 1'b0);
        check("R11 split frame", 12'h5A5, 12'h789);

        // R2: clocking while deselected, then one good frame
        sdi = 1'b1;
        for (int i = 0; i < 20; i++) begin
            #50 sclk = 1'b1;
            #50 sclk = 1'b0;
        end
        #200;
        check("R2 clocks ignored while deselected", 12'h5A5, 12'h789);
        send({1'b1, 2'b01, 12'h0F0, 1'b0}, 16, 1'b0, 1'b0);
        check("R2 frame after deselected clocks", 12'h5A5, 12'h0F0);

        // R10: short and long frames are discarded
        send({1'b0, 2'b01, 12'hFFF, 1'b0}, 15, 1'b0, 1'b0);
        check("R10 15-bit frame dropped", 12'h5A5, 12'h0F0);
        send({1'b1, 2'b01, 12'h111, 1'b0}, 17, 1'b0, 1'b0);
        check("R10 17-bit frame dropped", 12'h5A5, 12'h0F0);

        // R4: no update until the select is released
        send({1'b0, 2'b01, 12'h321, 1'b0}, 16, 1'b0, 1'b1);
        #200;
        check("R4 no update before select release", 12'h5A5, 12'h0F0);
        cs_n = 1'b1;
        #200;
        check("R4 update after select release", 12'h321, 12'h0F0);

        // R1: reset while running clears inputs as well as outputs
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        check("R1 reset clears outputs", 12'h000, 12'h000);
        send({1'b0, 2'b10, 12'hABC, 1'b0}, 16, 1'b0, 1'b0);
        check("R1 R7 inputs cleared by reset", 12'h000, 12'h000);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule